// File: doc/BRIEF.md
# ECC Write-Path Error Injector

This block sits between the ECC encoder and a 39-bit SRAM array (32 data bits in positions 0..31, 7 check bits in positions 32..38). On any cycle that carries a valid write it can flip chosen stored bits, so that the read-side decoder can be tested against known single-bit (correctable) and two-bit (non-correctable) faults. The corrupted word goes straight to the memory in the same cycle. Reads and idle cycles pass through untouched.

A 7-bit position code picks the bit. Codes 0..31 name data bits, and codes 64..70 name check bits 0..6. Every other code names nothing. Forcing can be continuous, through level inputs that stay high, or one-shot, through a pulse that arms a request. An armed request is spent by the first valid write after the arming cycle and is then cleared in hardware.

Top module: `ecc_err_inject`

## Requirements
- R1: When wr_valid_i is low, wr_word_o equals wr_word_i whatever the force inputs are.
- R2: With no continuous force input high and no one-shot request pending, a valid write passes through unchanged.
- R3: A single-bit request with position p in 0..31 inverts output bit p and no other bit.
- R4: A single-bit request with position p in 64..70 inverts output bit 32+(p-64), which is check bit p-64, and no other bit.
- R5: Positions 32..63 and 71..127 invert no bit, for both single-bit and two-bit requests.
- R6: A two-bit request at a valid position other than 64 inverts the selected bit and also output bit 32 (check bit 0, the odd-parity bit).
- R7: A two-bit request with position 64 leaves the write unchanged.
- R8: When a single-bit request and a two-bit request are both active, the two-bit behaviour applies.
- R9: A pulse on once_ce_i or once_nce_i arms a request that applies to the first valid write in a later cycle and is cleared by that write. The write after it is unchanged.
- R10: An arming pulse in the same cycle as the write that spends an earlier request keeps a request pending for the next valid write.
- R11: Reset clears any pending one-shot request.

Requirements R3 to R8 apply to both the continuous and the armed forms of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | The current cycle carries a write to memory |
| force_ce_i | input | 1 | Continuous single-bit inversion |
| force_nce_i | input | 1 | Continuous two-bit inversion |
| once_ce_i | input | 1 | Pulse that arms one single-bit inversion |
| once_nce_i | input | 1 | Pulse that arms one two-bit inversion |
| pos_i | input | 7 | Bit position code |
| wr_word_i | input | 39 | Encoded word from the encoder: data in 31:0, check bits in 38:32 |
| wr_word_o | output | 39 | Word to the memory, possibly corrupted |

## Verification
Two actions can fall in the same cycle: a write can spend an armed one-shot request while a new arming pulse arrives. The bench drives a pulse on the spending write itself. It judges the outcome over three writes: the colliding write must be corrupted, the following write must also be corrupted by the new request, and the write after that must be clean. A simultaneous single-bit and two-bit request is also provoked, and the output is checked against the two-bit pattern.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  typedef enum logic [1:0] {
    INJ_NONE   = 2'd0,
    INJ_SINGLE = 2'd1,
    INJ_DOUBLE = 2'd2
  } inj_mode_e;

  function automatic inj_mode_e resolve_mode(input logic valid, input logic ce, input logic nce);
    if (!valid)   return INJ_NONE;
    else if (nce) return INJ_DOUBLE;
    else if (ce)  return INJ_SINGLE;
    else          return INJ_NONE;
  endfunction
endpackage

// File: rtl/ecc_inj_pos_dec.sv
module ecc_inj_pos_dec #(
  parameter int DATA_W   = 32,
  parameter int ECC_W    = 7,
  parameter int POS_W    = 7,
  parameter int CHK_BASE = 64,
  localparam int WORD_W  = DATA_W + ECC_W
) (
  input  logic [POS_W-1:0]  pos_i,
  output logic [WORD_W-1:0] hit_o,
  output logic              par_sel_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_data
    assign hit_o[i] = (pos_i == POS_W'(i));
  end
  for (genvar j = 0; j < ECC_W; j++) begin : g_chk
    assign hit_o[DATA_W+j] = (pos_i == POS_W'(CHK_BASE + j));
  end
  // selecting the parity bit itself cancels a two-bit inversion
  assign par_sel_o = (pos_i == POS_W'(CHK_BASE));
endmodule

// File: rtl/ecc_inj_arm.sv
module ecc_inj_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic consume_i,
  output logic pend_o
);
  logic pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (set_i)     pend_q <= 1'b1;
    else if (consume_i) pend_q <= 1'b0;
  end
  assign pend_o = pend_q;
endmodule

// File: rtl/ecc_inj_mask.sv
module ecc_inj_mask
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ECC_W   = 7,
  localparam int WORD_W = DATA_W + ECC_W
) (
  input  inj_mode_e         mode_i,
  input  logic [WORD_W-1:0] hit_i,
  input  logic              par_sel_i,
  output logic [WORD_W-1:0] mask_o
);
  logic [WORD_W-1:0] par_bit;
  assign par_bit = WORD_W'(1) << DATA_W;

  always_comb begin
    mask_o = '0;
    unique case (mode_i)
      INJ_SINGLE: mask_o = hit_i;
      INJ_DOUBLE: if (|hit_i && !par_sel_i) mask_o = hit_i | par_bit;
      default:    mask_o = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_inject.sv
module ecc_err_inject
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ECC_W    = 7,
  parameter int POS_W    = 7,
  parameter int CHK_BASE = 64,
  localparam int WORD_W  = DATA_W + ECC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic              force_ce_i,
  input  logic              force_nce_i,
  input  logic              once_ce_i,
  input  logic              once_nce_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [WORD_W-1:0] wr_word_i,
  output logic [WORD_W-1:0] wr_word_o
);
  logic              ce_pend_q, nce_pend_q;
  logic [WORD_W-1:0] hit, mask;
  logic              par_sel;
  inj_mode_e         mode;

  ecc_inj_arm u_arm_ce (
    .clk_i, .rst_ni, .set_i(once_ce_i), .consume_i(wr_valid_i), .pend_o(ce_pend_q)
  );
  ecc_inj_arm u_arm_nce (
    .clk_i, .rst_ni, .set_i(once_nce_i), .consume_i(wr_valid_i), .pend_o(nce_pend_q)
  );

  ecc_inj_pos_dec #(.DATA_W(DATA_W), .ECC_W(ECC_W), .POS_W(POS_W), .CHK_BASE(CHK_BASE)) u_dec (
    .pos_i, .hit_o(hit), .par_sel_o(par_sel)
  );

  assign mode = resolve_mode(wr_valid_i, force_ce_i | ce_pend_q, force_nce_i | nce_pend_q);

  ecc_inj_mask #(.DATA_W(DATA_W), .ECC_W(ECC_W)) u_mask (
    .mode_i(mode), .hit_i(hit), .par_sel_i(par_sel), .mask_o(mask)
  );

  assign wr_word_o = wr_word_i ^ mask;
endmodule

// File: rtl/ecc_err_inject_chk.sv
module ecc_err_inject_chk #(
  parameter int DATA_W = 32,
  parameter int POS_W  = 7,
  parameter int WORD_W = 39
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              force_ce_i,
  input logic              force_nce_i,
  input logic              once_ce_i,
  input logic              once_nce_i,
  input logic [POS_W-1:0]  pos_i,
  input logic [WORD_W-1:0] wr_word_i,
  input logic [WORD_W-1:0] wr_word_o,
  input logic              ce_pend_q,
  input logic              nce_pend_q
);
  logic [WORD_W-1:0] diff;
  logic              any_nce, any_ce;
  assign diff    = wr_word_o ^ wr_word_i;
  assign any_nce = force_nce_i | nce_pend_q;
  assign any_ce  = force_ce_i | ce_pend_q;

  p_idle_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |-> diff == '0);
  p_no_force_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !any_ce && !any_nce) |-> diff == '0);
  p_single_one_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && any_ce && !any_nce && pos_i < POS_W'(DATA_W)) |-> $countones(diff) == 1);
  p_hole_none_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_i >= POS_W'(DATA_W) && pos_i < POS_W'(64)) |-> diff == '0);
  p_double_par_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && any_nce && pos_i < POS_W'(DATA_W)) |-> ($countones(diff) == 2 && diff[DATA_W]));
  p_double_64_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_nce && pos_i == POS_W'(64)) |-> diff == '0);
  p_spent_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !once_ce_i && !once_nce_i) |=> (!ce_pend_q && !nce_pend_q));
  p_arm_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    once_ce_i |=> ce_pend_q);
endmodule

bind ecc_err_inject ecc_err_inject_chk #(.DATA_W(DATA_W), .POS_W(POS_W), .WORD_W(WORD_W)) u_chk (
  .clk_i, .rst_ni, .wr_valid_i, .force_ce_i, .force_nce_i, .once_ce_i, .once_nce_i,
  .pos_i, .wr_word_i, .wr_word_o, .ce_pend_q, .nce_pend_q
);

// File: tb/tb_ecc_err_inject.sv
module tb_ecc_err_inject;
  localparam int CLK_PERIOD = 10;
  localparam int W = 39;

  typedef struct packed {
    logic       v;
    logic       ce;
    logic       nce;
    logic [6:0] pos;
    logic [W-1:0] w;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b1, 7'd5,   39'h12_3456_789A},  // R1 idle
    '{1'b1, 1'b0, 1'b0, 7'd5,   39'h12_3456_789A},  // R2 no force
    '{1'b1, 1'b1, 1'b0, 7'd0,   39'h00_0000_0000},  // R3
    '{1'b1, 1'b1, 1'b0, 7'd31,  39'h7F_FFFF_FFFF},  // R3
    '{1'b1, 1'b1, 1'b0, 7'd64,  39'h00_0000_0000},  // R4
    '{1'b1, 1'b1, 1'b0, 7'd70,  39'h55_AAAA_5555},  // R4
    '{1'b1, 1'b1, 1'b0, 7'd32,  39'h00_FFFF_0000},  // R5
    '{1'b1, 1'b1, 1'b0, 7'd63,  39'h01_0000_0001},  // R5
    '{1'b1, 1'b0, 1'b1, 7'd71,  39'h00_1234_5678},  // R5
    '{1'b1, 1'b0, 1'b1, 7'd127, 39'h7F_0000_0000},  // R5
    '{1'b1, 1'b0, 1'b1, 7'd7,   39'h00_0000_0000},  // R6
    '{1'b1, 1'b0, 1'b1, 7'd66,  39'h3C_DEAD_BEEF},  // R6
    '{1'b1, 1'b0, 1'b1, 7'd64,  39'h3C_DEAD_BEEF},  // R7
    '{1'b1, 1'b1, 1'b1, 7'd12,  39'h00_0000_0000},  // R8
    '{1'b1, 1'b1, 1'b1, 7'd64,  39'h11_1111_1111},  // R8
    '{1'b0, 1'b0, 1'b1, 7'd3,   39'h22_2222_2222}   // R1
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_valid_i = 1'b0, force_ce_i = 1'b0, force_nce_i = 1'b0;
  logic once_ce_i = 1'b0, once_nce_i = 1'b0;
  logic [6:0]   pos_i = '0;
  logic [W-1:0] wr_word_i = '0, wr_word_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ecc_err_inject dut (.*);

  // model built from the requirements
  function automatic logic [W-1:0] model(input logic [W-1:0] w, input logic v,
                                        input logic ce, input logic nce, input logic [6:0] p);
    int idx;
    if (!v || (!ce && !nce)) return w;
    if (p < 7'd32) idx = int'(p);
    else if (p >= 7'd64 && p <= 7'd70) idx = 32 + int'(p) - 64;
    else return w;
    if (nce) begin
      if (p == 7'd64) return w;
      return w ^ (W'(1) << idx) ^ (W'(1) << 32);
    end
    return w ^ (W'(1) << idx);
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (wr_word_o !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, wr_word_o, exp);
    end
  endtask

  task automatic drive(input logic v, input logic ce, input logic nce,
                       input logic oce, input logic once_n, input logic [6:0] p, input logic [W-1:0] w);
    @(negedge clk_i);
    wr_valid_i = v; force_ce_i = ce; force_nce_i = nce;
    once_ce_i = oce; once_nce_i = once_n; pos_i = p; wr_word_i = w;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] w0;
    w0 = 39'h0A_5A5A_A5A5;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R11 reset state: nothing pending
    drive(1, 0, 0, 0, 0, 7'd9, w0);
    check("R11 reset", w0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].v, VEC[i].ce, VEC[i].nce, 0, 0, VEC[i].pos, VEC[i].w);
      check($sformatf("R1-8 vec%0d", i), model(VEC[i].w, VEC[i].v, VEC[i].ce, VEC[i].nce, VEC[i].pos));
    end

    // R9 one-shot single-bit: idle cycles do not spend it
    drive(0, 0, 0, 1, 0, 7'd3, w0);
    check("R9 arm cycle idle", w0);
    drive(0, 0, 0, 0, 0, 7'd3, w0);
    check("R9 idle keeps", w0);
    drive(1, 0, 0, 0, 0, 7'd3, w0);
    check("R9 spent", w0 ^ (W'(1) << 3));
    drive(1, 0, 0, 0, 0, 7'd3, w0);
    check("R9 cleared", w0);

    // R9 one-shot two-bit at check bit 5
    drive(0, 0, 0, 0, 1, 7'd69, w0);
    drive(1, 0, 0, 0, 0, 7'd69, w0);
    check("R9 nce spent", w0 ^ (W'(1) << 37) ^ (W'(1) << 32));
    drive(1, 0, 0, 0, 0, 7'd69, w0);
    check("R9 nce cleared", w0);

    // R10 arm coincides with the spending write
    drive(0, 0, 0, 1, 0, 7'd20, w0);
    drive(1, 0, 0, 1, 0, 7'd20, w0);
    check("R10 collide", w0 ^ (W'(1) << 20));
    drive(1, 0, 0, 0, 0, 7'd20, w0);
    check("R10 rearmed", w0 ^ (W'(1) << 20));
    drive(1, 0, 0, 0, 0, 7'd20, w0);
    check("R10 cleared", w0);

    // R8 armed single with continuous two-bit
    drive(0, 0, 0, 1, 0, 7'd1, w0);
    drive(1, 0, 1, 0, 0, 7'd1, w0);
    check("R8 mix", w0 ^ (W'(1) << 1) ^ (W'(1) << 32));

    // R11 reset drops a pending request
    drive(0, 0, 0, 0, 1, 7'd4, w0);
    @(negedge clk_i);
    once_nce_i = 0;
    rst_ni = 1'b0;
    #2 rst_ni = 1'b1;
    drive(1, 0, 0, 0, 0, 7'd4, w0);
    check("R11 pending cleared", w0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    done = 1;
    $finish;
  end
endmodule